// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains and searches a singly linked chain of 32-bit capability headers held in a 4 KB configuration memory. The chain always begins at byte offset 256. Each header holds a 16-bit capability identifier in bits 15:0, a 4-bit version in bits 19:16, and the byte offset of the following header in bits 31:20. A next offset of zero ends the chain. The memory sits outside the block and is reached through a synchronous 32-bit port addressed in words (byte offset divided by four), with read data one cycle after the read strobe.

A search request carries an identifier. The block follows the chain one header per cycle and returns the offset of the first header whose identifier matches, together with the offset of the header before it. If nothing matches, it returns zero and the offset of the last header in the chain. Identifier zero is reserved as a key that never stands for a real capability, so searching for it returns the tail of the chain. An append request links a new header at a given offset onto the chain. Appending at offset 256 rewrites the first header in place and keeps its next field. Appending anywhere else finds the tail with the reserved key, points the tail at the new offset, and writes the new header with a zero next field. Malformed chains and illegal requests end with an error flag, not with a hang.

Top module: `ext_cap_walker`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, error, both result offsets and both memory strobes are 0 until a request is accepted.
- R2: Headers use bits 15:0 for the identifier, bits 19:16 for the version and bits 31:20 for the next byte offset. The memory word address is the byte offset divided by four, and no cycle reads and writes at once.
- R3: A search when the word at offset 256 is all zeros completes with result 0, previous 0 and no error.
- R4: A search returns the offset of the first matching header and the offset of the header before it (0 when the match is at 256). It writes nothing to memory, and results hold between completions.
- R5: A search that reaches a zero next field without a match returns result 0 and previous equal to the last header's offset. Searching for identifier 0 therefore yields the tail.
- R6: A next offset below 256, above 4088 or not a multiple of four ends the walk with error set and both results 0. The offset 4088 is legal. No read is ever issued outside words 64 to 1022.
- R7: A walk that has examined MaxSteps headers without ending stops with an error, so a circular chain cannot hang the block.
- R8: A request that examines k headers raises done for exactly one cycle, k cycles after the accepting clock edge. An append that links at a non-base offset takes k+2 cycles. A rejected append takes 0 cycles. Busy is high from acceptance through done.
- R9: An append at offset 256 writes {old next of word 64, new version, new identifier} into word 64. It returns result 256 and previous 0, and it works on an empty chain.
- R10: An append at any other legal offset first rewrites the tail header's next field to the new offset, keeping its low 20 bits. It then writes {0, version, identifier} at the new offset and returns result = new offset, previous = tail offset.
- R11: An append whose offset is below 256 or not a multiple of four, whose size is below 8, or whose offset plus size reaches 4096 ends with error and writes nothing.
- R12: An append at a non-base offset onto an empty chain, or onto a chain that contains a header with identifier 0, ends with error and writes nothing.
- R13: A request presented while busy is ignored. It changes no result and starts no later operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqOp | input | 1 | 0 = search, 1 = append |
| reqCapId | input | 16 | Identifier to find or to append |
| reqVersion | input | 4 | Version field for an append |
| reqOffset | input | 12 | Byte offset of the header to append |
| reqSize | input | 13 | Byte length of the appended capability |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operation failed |
| resultOffset | output | 12 | Matching or appended header offset |
| resultPrev | output | 12 | Offset of the header before the result |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 10 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, one cycle after the read strobe |

## Verification
The hardest condition to reach from the ports is the step limit. It only fires on a chain that never ends, and no legal sequence of appends can build one. The bench therefore writes the memory model directly to make a header that points back at itself, then searches for an absent identifier and expects the error after exactly MaxSteps cycles. Broken next offsets (misaligned, below the base, above the last legal slot) and a zero identifier hidden in the chain are planted the same way, just before the searches and appends that must trip over them.

// File: rtl/ecw_pkg.sv
package ecw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_LINK,
    ST_PLACE,
    ST_FINISH
  } walkState_t;

  typedef enum logic [2:0] {
    RS_HIT,
    RS_TAIL,
    RS_EMPTY,
    RS_FAULT,
    RS_APP_BASE,
    RS_APP_LINK
  } resSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadReq;
    logic    rdBase;
    logic    rdNext;
    logic    saveTail;
    logic    wrBase;
    logic    wrLink;
    logic    wrPlace;
    logic    resLoad;
    resSel_t resSel;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reqAppend;
    logic reqBad;
    logic isAppend;
    logic atBase;
    logic hdrZero;
    logic idMatch;
    logic nextZero;
    logic nextBad;
  } dpStat_t;

endpackage

// File: rtl/ecw_ctrl.sv
module ecw_ctrl
  import ecw_pkg::*;
#(
  parameter int MaxSteps = 1024
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    busy,
  output logic    done
);

  localparam int StepW = (MaxSteps > 1) ? $clog2(MaxSteps) : 1;
  localparam logic [StepW-1:0] LastStep = StepW'(MaxSteps - 1);

  walkState_t       state, stateNxt;
  logic             firstHdr;
  logic [StepW-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == LastStep);

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          cmd.loadReq = 1'b1;
          if (stat.reqAppend && stat.reqBad) begin
            cmd.resLoad = 1'b1;
            cmd.resSel  = RS_FAULT;
            stateNxt    = ST_FINISH;
          end else begin
            cmd.rdBase = 1'b1;
            stateNxt   = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (firstHdr && stat.isAppend && stat.atBase) begin
          cmd.wrBase  = 1'b1;
          cmd.resLoad = 1'b1;
          cmd.resSel  = RS_APP_BASE;
          stateNxt    = ST_FINISH;
        end else if (firstHdr && stat.hdrZero) begin
          cmd.resLoad = 1'b1;
          cmd.resSel  = stat.isAppend ? RS_FAULT : RS_EMPTY;
          stateNxt    = ST_FINISH;
        end else if (stat.idMatch) begin
          cmd.resLoad = 1'b1;
          cmd.resSel  = stat.isAppend ? RS_FAULT : RS_HIT;
          stateNxt    = ST_FINISH;
        end else if (stat.nextZero) begin
          if (stat.isAppend) begin
            cmd.saveTail = 1'b1;
            stateNxt     = ST_LINK;
          end else begin
            cmd.resLoad = 1'b1;
            cmd.resSel  = RS_TAIL;
            stateNxt    = ST_FINISH;
          end
        end else if (stat.nextBad || lastStep) begin
          cmd.resLoad = 1'b1;
          cmd.resSel  = RS_FAULT;
          stateNxt    = ST_FINISH;
        end else begin
          cmd.rdNext = 1'b1;
        end
      end
      ST_LINK: begin
        cmd.wrLink = 1'b1;
        stateNxt   = ST_PLACE;
      end
      ST_PLACE: begin
        cmd.wrPlace = 1'b1;
        cmd.resLoad = 1'b1;
        cmd.resSel  = RS_APP_LINK;
        stateNxt    = ST_FINISH;
      end
      ST_FINISH: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      firstHdr <= 1'b0;
      stepCnt  <= '0;
    end else begin
      state <= stateNxt;
      if (cmd.loadReq)          firstHdr <= 1'b1;
      else if (state == ST_WALK) firstHdr <= 1'b0;
      if (cmd.loadReq)      stepCnt <= '0;
      else if (cmd.rdNext)  stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/ecw_datapath.sv
module ecw_datapath
  import ecw_pkg::*;
#(
  parameter int IdW        = 16,
  parameter int VerW       = 4,
  parameter int OffW       = 12,
  parameter int BaseOff    = 256,
  parameter int SpaceBytes = 4096
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCmd_t                    cmd,
  output dpStat_t                   stat,
  input  logic                      reqOp,
  input  logic [IdW-1:0]            reqCapId,
  input  logic [VerW-1:0]           reqVersion,
  input  logic [OffW-1:0]           reqOffset,
  input  logic [OffW:0]             reqSize,
  input  logic [IdW+VerW+OffW-1:0]  memRdata,
  output logic                      memRdEn,
  output logic                      memWrEn,
  output logic [OffW-3:0]           memAddr,
  output logic [IdW+VerW+OffW-1:0]  memWdata,
  output logic [OffW-1:0]           resultOffset,
  output logic [OffW-1:0]           resultPrev,
  output logic                      error
);

  localparam int HdrW  = IdW + VerW + OffW;
  localparam int LowW  = IdW + VerW;
  localparam int WordW = OffW - 2;
  localparam logic [OffW-1:0]  BaseO    = OffW'(BaseOff);
  localparam logic [OffW-1:0]  MaxO     = OffW'(SpaceBytes - 8);
  localparam logic [WordW-1:0] BaseWord = WordW'(BaseOff / 4);
  localparam logic [OffW:0]    MinSize  = (OffW+1)'(8);
  localparam logic [OffW+1:0]  EndLimit = (OffW+2)'(SpaceBytes);

  logic             isApp;
  logic [IdW-1:0]   key;
  logic [IdW-1:0]   newId;
  logic [VerW-1:0]  newVer;
  logic [OffW-1:0]  newOff;
  logic [OffW-1:0]  curOff;
  logic [OffW-1:0]  prevOff;
  logic [OffW-1:0]  tailOff;
  logic [LowW-1:0]  tailLow;

  logic [IdW-1:0]   hdrId;
  logic [OffW-1:0]  hdrNext;
  logic [OffW+1:0]  reqEnd;

  assign hdrId   = memRdata[IdW-1:0];
  assign hdrNext = memRdata[HdrW-1 -: OffW];
  assign reqEnd  = {2'b00, reqOffset} + {1'b0, reqSize};

  // condition flags for the control
  always_comb begin
    stat.reqAppend = reqOp;
    stat.reqBad    = (reqOffset < BaseO) || (reqOffset[1:0] != 2'b00) ||
                     (reqSize < MinSize) || (reqEnd >= EndLimit);
    stat.isAppend  = isApp;
    stat.atBase    = (newOff == BaseO);
    stat.hdrZero   = (memRdata == '0);
    stat.idMatch   = (hdrId == key);
    stat.nextZero  = (hdrNext == '0);
    stat.nextBad   = (hdrNext < BaseO) || (hdrNext > MaxO) || (hdrNext[1:0] != 2'b00);
  end

  // memory port steering
  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memRdEn  = cmd.rdBase | cmd.rdNext;
    memWrEn  = cmd.wrBase | cmd.wrLink | cmd.wrPlace;
    if (cmd.rdBase) begin
      memAddr = BaseWord;
    end else if (cmd.rdNext) begin
      memAddr = hdrNext[OffW-1:2];
    end else if (cmd.wrBase) begin
      memAddr  = BaseWord;
      memWdata = {hdrNext, newVer, newId};
    end else if (cmd.wrLink) begin
      memAddr  = tailOff[OffW-1:2];
      memWdata = {newOff, tailLow};
    end else if (cmd.wrPlace) begin
      memAddr  = newOff[OffW-1:2];
      memWdata = {{OffW{1'b0}}, newVer, newId};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isApp   <= 1'b0;
      key     <= '0;
      newId   <= '0;
      newVer  <= '0;
      newOff  <= '0;
      curOff  <= '0;
      prevOff <= '0;
      tailOff <= '0;
      tailLow <= '0;
    end else begin
      if (cmd.loadReq) begin
        isApp   <= reqOp;
        key     <= reqOp ? '0 : reqCapId;
        newId   <= reqCapId;
        newVer  <= reqVersion;
        newOff  <= reqOffset;
        curOff  <= BaseO;
        prevOff <= '0;
      end else if (cmd.rdNext) begin
        prevOff <= curOff;
        curOff  <= hdrNext;
      end
      if (cmd.saveTail) begin
        tailOff <= curOff;
        tailLow <= memRdata[LowW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOffset <= '0;
      resultPrev   <= '0;
      error        <= 1'b0;
    end else if (cmd.resLoad) begin
      resultOffset <= '0;
      resultPrev   <= '0;
      error        <= 1'b0;
      case (cmd.resSel)
        RS_HIT: begin
          resultOffset <= curOff;
          resultPrev   <= prevOff;
        end
        RS_TAIL:     resultPrev <= curOff;
        RS_FAULT:    error <= 1'b1;
        RS_APP_BASE: resultOffset <= BaseO;
        RS_APP_LINK: begin
          resultOffset <= newOff;
          resultPrev   <= tailOff;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ext_cap_walker.sv
module ext_cap_walker
  import ecw_pkg::*;
#(
  parameter int IdW        = 16,
  parameter int VerW       = 4,
  parameter int SpaceBytes = 4096,
  parameter int BaseOff    = 256,
  parameter int MaxSteps   = 1024,
  localparam int OffW      = $clog2(SpaceBytes),
  localparam int HdrW      = IdW + VerW + OffW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqOp,
  input  logic [IdW-1:0]    reqCapId,
  input  logic [VerW-1:0]   reqVersion,
  input  logic [OffW-1:0]   reqOffset,
  input  logic [OffW:0]     reqSize,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [OffW-1:0]   resultOffset,
  output logic [OffW-1:0]   resultPrev,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [OffW-3:0]   memAddr,
  output logic [HdrW-1:0]   memWdata,
  input  logic [HdrW-1:0]   memRdata
);

  dpCmd_t  cmd;
  dpStat_t stat;

  ecw_ctrl #(
    .MaxSteps(MaxSteps)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .stat    (stat),
    .cmd     (cmd),
    .busy    (busy),
    .done    (done)
  );

  ecw_datapath #(
    .IdW       (IdW),
    .VerW      (VerW),
    .OffW      (OffW),
    .BaseOff   (BaseOff),
    .SpaceBytes(SpaceBytes)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .stat        (stat),
    .reqOp       (reqOp),
    .reqCapId    (reqCapId),
    .reqVersion  (reqVersion),
    .reqOffset   (reqOffset),
    .reqSize     (reqSize),
    .memRdata    (memRdata),
    .memRdEn     (memRdEn),
    .memWrEn     (memWrEn),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .resultOffset(resultOffset),
    .resultPrev  (resultPrev),
    .error       (error)
  );

endmodule

// File: rtl/ecw_checker.sv
module ecw_checker #(
  parameter int OffW       = 12,
  parameter int BaseOff    = 256,
  parameter int SpaceBytes = 4096
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            busy,
  input logic            done,
  input logic            error,
  input logic [OffW-1:0] resultOffset,
  input logic [OffW-1:0] resultPrev,
  input logic            memRdEn,
  input logic            memWrEn,
  input logic [OffW-3:0] memAddr
);

  localparam logic [OffW-3:0] LoWord = (OffW-2)'(BaseOff / 4);
  localparam logic [OffW-3:0] HiWord = (OffW-2)'((SpaceBytes - 8) / 4);

  p_single_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_no_mixed_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  p_write_only_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWrEn);

  p_error_clears_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (resultOffset == '0 && resultPrev == '0));

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |=> ($stable(resultOffset) && $stable(resultPrev) && $stable(error)));

  p_read_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr >= LoWord && memAddr <= HiWord));

endmodule

bind ext_cap_walker ecw_checker #(
  .OffW      (OffW),
  .BaseOff   (BaseOff),
  .SpaceBytes(SpaceBytes)
) u_ecw_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .resultOffset(resultOffset),
  .resultPrev  (resultPrev),
  .memRdEn     (memRdEn),
  .memWrEn     (memWrEn),
  .memAddr     (memAddr)
);

// File: tb/ext_cap_walker_bench.sv
module ext_cap_walker_bench;

  localparam int MaxSteps = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqOp = 1'b0;
  logic [15:0] reqCapId = '0;
  logic [3:0]  reqVersion = '0;
  logic [11:0] reqOffset = '0;
  logic [12:0] reqSize = '0;
  logic        busy, done, error;
  logic [11:0] resultOffset, resultPrev;
  logic        memRdEn, memWrEn;
  logic [9:0]  memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  logic [31:0] mem    [1024];
  logic [31:0] shadow [1024];

  int  tests = 0;
  int  fails = 0;
  bit  sawWrite = 0;

  always #10 clk = ~clk;

  ext_cap_walker #(.MaxSteps(MaxSteps)) u_ext_cap_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqCapId(reqCapId), .reqVersion(reqVersion), .reqOffset(reqOffset),
    .reqSize(reqSize), .busy(busy), .done(done), .error(error),
    .resultOffset(resultOffset), .resultPrev(resultPrev),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWdata;
    if (memRdEn) memRdata <= mem[memAddr];
  end

  // every clock: note any write strobe
  always @(negedge clk) if (rstN && memWrEn) sawWrite = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
  endtask

  task automatic putHdr(input int off, input logic [15:0] id, input logic [3:0] ver, input int nxt);
    mem[off/4] = {nxt[11:0], ver, id};
    shadow[off/4] = {nxt[11:0], ver, id};
  endtask

  // behavioural reference: walks and edits the shadow copy
  task automatic modelOp(input bit op, input logic [15:0] id, input logic [3:0] ver,
                         input int off, input int size,
                         output int eRes, output int ePrev, output bit eErr, output int eLat);
    int cur, prv, visits, nxt;
    logic [31:0] h;
    logic [15:0] key;
    bit fin, hit;
    eRes = 0; ePrev = 0; eErr = 0; eLat = 0;
    if (op) begin
      if (off < 256 || off % 4 != 0 || size < 8 || off + size >= 4096) begin
        eErr = 1; eLat = 0; return;
      end
      if (off == 256) begin
        shadow[64] = {shadow[64][31:20], ver, id};
        eRes = 256; eLat = 1; return;
      end
    end
    key = op ? 16'h0 : id;
    if (shadow[64] == 32'h0) begin
      eLat = 1; eErr = op; return;
    end
    cur = 256; prv = 0; visits = 0; fin = 0; hit = 0;
    while (!fin) begin
      h = shadow[cur/4];
      visits++;
      nxt = int'(h[31:20]);
      if (h[15:0] == key) begin hit = 1; fin = 1; end
      else if (nxt == 0) fin = 1;
      else if (nxt < 256 || nxt > 4088 || nxt % 4 != 0 || visits == MaxSteps) begin
        eErr = 1; fin = 1;
      end else begin prv = cur; cur = nxt; end
    end
    eLat = visits;
    if (eErr) return;
    if (!op) begin
      if (hit) begin eRes = cur; ePrev = prv; end
      else ePrev = cur;
      return;
    end
    if (hit) begin eErr = 1; return; end
    shadow[cur/4] = {off[11:0], shadow[cur/4][19:0]};
    shadow[off/4] = {12'h0, ver, id};
    eRes = off; ePrev = cur; eLat = visits + 2;
  endtask

  task automatic runOp(input bit op, input logic [15:0] id, input logic [3:0] ver,
                       input int off, input int size, input string tag, input bit inject);
    int eRes, ePrev, eLat, lat, bad;
    bit eErr, busyOk;
    modelOp(op, id, ver, off, size, eRes, ePrev, eErr, eLat);
    @(negedge clk);
    reqValid = 1; reqOp = op; reqCapId = id; reqVersion = ver;
    reqOffset = off[11:0]; reqSize = size[12:0]; sawWrite = 0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0; lat = 0; busyOk = 1;
    while (!done && lat < 4000) begin
      if (!busy) busyOk = 0;
      if (inject && lat == 1) begin
        // R13: foreign request while busy
        reqValid = 1; reqOp = 1; reqOffset = 12'h080; reqSize = 13'd16;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      reqValid = 0;
    end
    chk(lat == eLat, {tag, " R8 done latency"}, lat, eLat);
    chk(busyOk, {tag, " R8 busy until done"}, busyOk, 1);
    chk(int'(resultOffset) == eRes, {tag, " result offset"}, resultOffset, eRes);
    chk(int'(resultPrev) == ePrev, {tag, " previous offset"}, resultPrev, ePrev);
    chk(error == eErr, {tag, " error flag"}, error, eErr);
    if (!op) chk(!sawWrite, {tag, " R4 search writes nothing"}, sawWrite, 0);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, {tag, " R2 memory contents"}, bad, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done && !busy, {tag, " R13 idle afterwards"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clearMem();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !error && !memRdEn && !memWrEn, "R1 during reset", {busy, done, error}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(resultOffset == 0 && resultPrev == 0 && !busy && !memRdEn && !memWrEn,
        "R1 after release", resultOffset, 0);

    runOp(0, 16'h0001, 4'h0, 0, 0, "R3 empty search", 0);

    putHdr(256,  16'h0001, 4'h1, 320);
    putHdr(320,  16'h000E, 4'h2, 1024);
    putHdr(1024, 16'h0010, 4'h1, 0);
    runOp(0, 16'h0001, 4'h0, 0, 0, "R4 hit at base", 0);
    runOp(0, 16'h000E, 4'h0, 0, 0, "R4 R13 hit middle with busy request", 1);
    runOp(0, 16'h1234, 4'h0, 0, 0, "R5 miss gives tail", 0);
    runOp(0, 16'h0000, 4'h0, 0, 0, "R5 reserved id gives tail", 0);

    runOp(1, 16'h0019, 4'h1, 128,  32, "R11 offset below base", 0);
    runOp(1, 16'h0019, 4'h1, 1282, 32, "R11 misaligned offset", 0);
    runOp(1, 16'h0019, 4'h1, 1280, 4,  "R11 size too small", 0);
    runOp(1, 16'h0019, 4'h1, 4080, 16, "R11 reaches end of space", 0);

    runOp(1, 16'h0019, 4'h1, 1536, 32, "R10 R2 link append", 0);
    runOp(0, 16'h0019, 4'h0, 0, 0, "R4 find appended", 0);
    runOp(1, 16'h0023, 4'h2, 256, 16, "R9 base append", 0);

    putHdr(1536, 16'h0019, 4'h1, 1794);
    runOp(0, 16'h7777, 4'h0, 0, 0, "R6 misaligned next", 0);
    putHdr(1536, 16'h0019, 4'h1, 240);
    runOp(0, 16'h7777, 4'h0, 0, 0, "R6 next below base", 0);
    putHdr(1536, 16'h0019, 4'h1, 4092);
    runOp(0, 16'h7777, 4'h0, 0, 0, "R6 next above limit", 0);
    putHdr(1536, 16'h0019, 4'h1, 4088);
    runOp(0, 16'h7777, 4'h0, 0, 0, "R6 last legal offset", 0);
    runOp(1, 16'h0031, 4'h1, 2048, 16, "R12 zero id in chain", 0);

    clearMem();
    runOp(1, 16'h0031, 4'h1, 768, 16, "R12 empty chain append", 0);
    runOp(1, 16'h0031, 4'h3, 256, 8, "R9 base append on empty chain", 0);

    clearMem();
    putHdr(256, 16'h0005, 4'h1, 256);
    runOp(0, 16'h0009, 4'h0, 0, 0, "R7 circular chain", 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule